// File: doc/BRIEF.md
# DMA Request Fairness Throttle

This block sits on the path from a parallel-port DMA engine to the system DMA request line. It passes the engine's raw request through, but it counts the bus cycles (transfer strobes) granted while the request is up. Once a programmable number of consecutive bus cycles has been served, it pulls the request low and holds it low for a programmable number of clock cycles. This gives other bus masters a turn before the port may ask again.

An 8-bit control register holds a 3-bit burst field and a 3-bit hold-off field, and the other two bits are reserved. A burst field of 0 allows one bus cycle; any other value n allows 4(n+1) bus cycles. The hold-off field n gives 8 + 32n clock cycles. The burst limit is latched when a burst starts and the hold-off length is latched when a hold-off starts, so a write never changes a limit that is already running. If the raw request drops before the limit is reached, the count is discarded and no hold-off follows.

Top module: `dma_fair_throttle`

## Requirements
- R1: While reset is asserted, and on its release, `req_out` is 0 and `cfg_rdata` reads 0x07 (burst field 7, hold-off field 0).
- R2: `req_out` is never 1 in a cycle where `req_raw` is 0.
- R3: With the burst field (bits 2:0) at 0, the request is cut after exactly 1 bus cycle; with a strobe every clock it is high for 1 clock.
- R4: With a nonzero burst field n, the request is cut after exactly 4(n+1) bus cycles, counted one per `xfer_stb` pulse while `req_out` is high.
- R5: After a cut, `req_out` stays low for exactly 8 + 32m clock cycles, where m is the hold-off field (bits 6:4).
- R6: During a hold-off, `req_out` is 0 whatever `req_raw` and `xfer_stb` do.
- R7: If `req_raw` drops before the burst limit is reached, no hold-off follows, and the next burst starts from a count of zero.
- R8: Strobes that arrive while `req_raw` is 0 are not counted.
- R9: Bits 3 and 7 of the register read as 0, and writes to them have no effect; bits 2:0 and 6:4 read back as written.
- R10: A register write during a burst or a hold-off does not change that burst or hold-off; the new value applies from the next one.
- R11: When a hold-off ends with `req_raw` still high, `req_out` rises in the next cycle and a full new burst is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_raw | input | 1 | Raw DMA request from the port engine |
| xfer_stb | input | 1 | One-cycle pulse per bus cycle served |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| req_out | output | 1 | Throttled DMA request |

## Verification
The assertions assume that `xfer_stb` pulses only stand for bus cycles of this port. A strobe seen while the request is low is treated as stray, and the checks on burst length ignore it. They also assume that every input is steady at the clock edge. The bench changes inputs one time unit after the rising edge and samples at the falling edge. It raises strobes while the raw request is low only in the test where those strobes are meant to be ignored. The sweep covers every pair of burst and hold-off field values with a strobe on every clock, so each expected length follows directly from the field formulas.

// File: rtl/dft_pkg.sv
package dft_pkg;

  localparam int CFG_W      = 8;
  localparam int ACT_FW     = 3;
  localparam int HOLD_FW    = 3;
  localparam int ACT_LSB    = 0;
  localparam int HOLD_LSB   = 4;
  localparam int BURST_STEP = 4;
  localparam int HOLD_BASE  = 8;
  localparam int HOLD_STEP  = 32;
  localparam logic [CFG_W-1:0] CFG_RST  = 8'h07;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'h77;

  localparam int BURST_MAX = BURST_STEP * (2 ** ACT_FW);
  localparam int BURST_CW  = $clog2(BURST_MAX + 1);
  localparam int HOLD_MAX  = HOLD_BASE + HOLD_STEP * ((2 ** HOLD_FW) - 1);
  localparam int HOLD_CW   = $clog2(HOLD_MAX + 1);

  function automatic logic [BURST_CW-1:0] burst_len(input logic [ACT_FW-1:0] f);
    int v;
    if (f == '0) v = 1;
    else         v = BURST_STEP * (int'(f) + 1);
    return BURST_CW'(v);
  endfunction

  function automatic logic [HOLD_CW-1:0] hold_len(input logic [HOLD_FW-1:0] f);
    int v;
    v = HOLD_BASE + HOLD_STEP * int'(f);
    return HOLD_CW'(v);
  endfunction

endpackage

// File: rtl/dft_rst_sync.sv
module dft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dft_cfg_reg.sv
module dft_cfg_reg
  import dft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [ACT_FW-1:0]  act_field,
  output logic [HOLD_FW-1:0] hold_field
);

  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RST;
    else if (we) cfg_q <= cfg_d;
  end

  assign act_field  = cfg_q[ACT_LSB  +: ACT_FW];
  assign hold_field = cfg_q[HOLD_LSB +: HOLD_FW];

endmodule

// File: rtl/dft_burst_ctr.sv
module dft_burst_ctr
  import dft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req_raw,
  input  logic              xfer_stb,
  input  logic [ACT_FW-1:0] act_field,
  output logic              burst_done
);

  logic                in_burst_q, in_burst_d;
  logic [BURST_CW-1:0] cnt_q, cnt_d;
  logic [BURST_CW-1:0] lim_q, lim_d;
  logic [BURST_CW-1:0] eff_lim;
  logic                active;
  logic                lim_en;

  always_comb begin
    active     = en & req_raw;
    lim_d      = burst_len(act_field);
    eff_lim    = in_burst_q ? lim_q : lim_d;
    lim_en     = active & ~in_burst_q;
    burst_done = active & xfer_stb & ((cnt_q + BURST_CW'(1)) == eff_lim);
    in_burst_d = active & ~burst_done;
    if (!active || burst_done) cnt_d = '0;
    else if (xfer_stb)         cnt_d = cnt_q + BURST_CW'(1);
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      in_burst_q <= in_burst_d;
      cnt_q      <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end

endmodule

// File: rtl/dft_hold_timer.sv
module dft_hold_timer
  import dft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [HOLD_FW-1:0] hold_field,
  output logic               hold_act
);

  logic               hold_q, hold_d;
  logic [HOLD_CW-1:0] rem_q, rem_d;
  logic               rem_en;

  always_comb begin
    rem_en = start | hold_q;
    hold_d = hold_q;
    rem_d  = rem_q;
    if (start) begin
      hold_d = 1'b1;
      rem_d  = hold_len(hold_field);
    end else if (hold_q) begin
      if (rem_q == HOLD_CW'(1)) begin
        hold_d = 1'b0;
        rem_d  = '0;
      end else begin
        rem_d  = rem_q - HOLD_CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign hold_act = hold_q;

endmodule

// File: rtl/dma_fair_throttle.sv
module dma_fair_throttle
  import dft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_raw,
  input  logic             xfer_stb,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             req_out
);

  logic               rst_sync_n;
  logic [ACT_FW-1:0]  act_field;
  logic [HOLD_FW-1:0] hold_field;
  logic               burst_done;
  logic               hold_act;

  dft_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dft_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .cfg_q      (cfg_rdata),
    .act_field  (act_field),
    .hold_field (hold_field)
  );

  dft_burst_ctr u_burst (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (~hold_act),
    .req_raw    (req_raw),
    .xfer_stb   (xfer_stb),
    .act_field  (act_field),
    .burst_done (burst_done)
  );

  dft_hold_timer u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (burst_done),
    .hold_field (hold_field),
    .hold_act   (hold_act)
  );

  assign req_out = req_raw & ~hold_act & rst_sync_n;

endmodule

// File: rtl/dma_fair_throttle_chk.sv
module dma_fair_throttle_chk
  import dft_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_raw,
  input logic             xfer_stb,
  input logic             req_out,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             hold_act
);

  logic [BURST_CW-1:0] run_q;
  logic [HOLD_CW:0]    hlen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (!req_out) run_q <= '0;
    else if (xfer_stb) run_q <= run_q + BURST_CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hlen_q <= '0;
    else if (hold_act) hlen_q <= hlen_q + (HOLD_CW+1)'(1);
    else               hlen_q <= '0;
  end

  AST_OUT_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> req_raw); // R2

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !req_out); // R6

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BURST_CW'(BURST_MAX)); // R4

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_act && hlen_q != '0) |-> (hlen_q >= (HOLD_CW+1)'(HOLD_BASE))); // R5

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> $past(req_out && xfer_stb)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] == 1'b0) && (cfg_rdata[7] == 1'b0)); // R9

endmodule

bind dma_fair_throttle dma_fair_throttle_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_raw   (req_raw),
  .xfer_stb  (xfer_stb),
  .req_out   (req_out),
  .cfg_rdata (cfg_rdata),
  .hold_act  (hold_act)
);

// File: tb/dma_fair_throttle_bench.sv
`timescale 1ns/1ps
module dma_fair_throttle_bench;

  logic       clk;
  logic       rst_n;
  logic       req_raw;
  logic       xfer_stb;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       req_out;

  int checks;
  int fails;
  bit done;

  dma_fair_throttle u_dma_fair_throttle (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_raw   (req_raw),
    .xfer_stb  (xfer_stb),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_out   (req_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      req_raw = 1'b0; xfer_stb = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    req_raw = 1'b0; xfer_stb = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Raw request held high; strobe every gap cycles. Counts cycles of the
  // first high run, the low run after it and the second high run.
  task automatic measure(input int gap, input int wr_phase, input int wr_at,
                         input logic [7:0] wr_val,
                         output int hi1, output int lo, output int hi2);
    int phase;
    int k;
    phase = 0; k = 0; hi1 = 0; lo = 0; hi2 = 0;
    while (phase < 3 && k < 1000) begin
      @(posedge clk); #1;
      req_raw  = 1'b1;
      xfer_stb = ((k % gap) == 0);
      cfg_we   = 1'b0;
      if ((wr_phase == 0 && phase == 0 && hi1 == wr_at) ||
          (wr_phase == 1 && phase == 1 && lo == wr_at)) begin
        cfg_we = 1'b1; cfg_wdata = wr_val;
      end
      @(negedge clk);
      case (phase)
        0: if (req_out) hi1++; else begin phase = 1; lo = 1; end
        1: if (!req_out) lo++; else begin phase = 2; hi2 = 1; end
        default: if (req_out) hi2++; else phase = 3;
      endcase
      k++;
    end
    @(posedge clk); #1;
    req_raw = 1'b0; xfer_stb = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi1, lo, hi2, len, hold;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; req_raw = 1'b1; xfer_stb = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out in reset", int'(req_out), 0);
    chk("R1 cfg in reset", int'(cfg_rdata), 8'h07);
    req_raw = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    chk("R1 cfg after reset", int'(cfg_rdata), 8'h07);
    chk("R1 out after reset", int'(req_out), 0);

    // R9 reserved bits
    wr_cfg(8'hFF); @(negedge clk); chk("R9 write ff", int'(cfg_rdata), 8'h77);
    wr_cfg(8'h88); @(negedge clk); chk("R9 write 88", int'(cfg_rdata), 8'h00);
    wr_cfg(8'h35); @(negedge clk); chk("R9 write 35", int'(cfg_rdata), 8'h35);

    // Full sweep of both fields: R3 R4 R5 R11
    for (int a = 0; a < 8; a++) begin
      for (int h = 0; h < 8; h++) begin
        len  = (a == 0) ? 1 : 4 * (a + 1);
        hold = 8 + 32 * h;
        wr_cfg(8'((h << 4) | a));
        idle(2);
        measure(1, -1, 0, 8'h00, hi1, lo, hi2);
        chk((a == 0) ? "R3 burst" : "R4 burst", hi1, len);
        chk("R5 hold", lo, hold);
        chk("R11 next burst", hi2, len);
        idle(hold + 4);
      end
    end

    // Sparse strobes, R4 R5
    wr_cfg(8'h01); idle(2);
    measure(2, -1, 0, 8'h00, hi1, lo, hi2);
    chk("R4 gap2 high cycles", hi1, 15);
    chk("R5 gap2 hold", lo, 8);
    idle(20);

    // R7 early drop
    @(posedge clk); #1; req_raw = 1'b1; xfer_stb = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    req_raw = 1'b0; xfer_stb = 1'b0;
    @(negedge clk); chk("R2 out low with raw low", int'(req_out), 0);
    @(posedge clk); #1; req_raw = 1'b1;
    @(negedge clk); chk("R7 no hold after drop", int'(req_out), 1);
    measure(1, -1, 0, 8'h00, hi1, lo, hi2);
    chk("R7 fresh burst", hi1, 8);
    idle(20);

    // R8 strobes with raw low
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1; req_raw = 1'b0; xfer_stb = 1'b1;
    end
    measure(1, -1, 0, 8'h00, hi1, lo, hi2);
    chk("R8 burst after stray strobes", hi1, 8);
    idle(20);

    // R6 raw toggling during hold
    wr_cfg(8'h00); idle(2);
    @(posedge clk); #1; req_raw = 1'b1; xfer_stb = 1'b1;
    @(negedge clk); chk("R3 single cycle high", int'(req_out), 1);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1; req_raw = i[0]; xfer_stb = 1'b1;
      @(negedge clk); chk("R6 low during hold", int'(req_out), 0);
    end
    @(posedge clk); #1; req_raw = 1'b1; xfer_stb = 1'b0;
    @(negedge clk); chk("R6 release after hold", int'(req_out), 1);
    idle(20);

    // R10 write during burst
    wr_cfg(8'h07); idle(2);
    measure(1, 0, 4, 8'h00, hi1, lo, hi2);
    chk("R10 burst kept", hi1, 32);
    chk("R10 hold kept", lo, 8);
    chk("R10 new burst", hi2, 1);
    idle(20);

    // R10 write during hold
    wr_cfg(8'h00); idle(2);
    measure(1, 1, 2, 8'h10, hi1, lo, hi2);
    chk("R10 burst", hi1, 1);
    chk("R10 hold unchanged", lo, 8);
    idle(50);
    measure(1, -1, 0, 8'h00, hi1, lo, hi2);
    chk("R10 new hold", lo, 40);
    idle(50);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule